// File: doc/BRIEF.md
# Pixel Output Port Demultiplexer

This block sits after a pixel sampler. It takes at most one pixel per clock, qualified by a valid input, and routes it to one of two output ports, A and B. A horizontal sync input marks the start of each line. The rising edge of sync restarts the pixel count of the line. It also loads the three configuration bits that govern the line: the single or dual port choice, the interleaved or simultaneous presentation, and the port that takes the first pixel.

In single-port mode every pixel lands on port A, and the port B output enable is deasserted so that the pads can float. In dual-port mode the pixels alternate between the ports, and two presentations are possible. In interleaved presentation each pixel updates its own port in the cycle after it arrives. In simultaneous presentation the first pixel of each pair waits in a staging register until its partner arrives, and then both ports update together.

A one-cycle data clock enable pulses with every port update. A line-level data-valid flag rises with the first update of a line and is cleared by the next sync leading edge. Control is a small state machine with three states. SINGLE applies to a single-port line. FIRST means the next pixel opens a pair, and SECOND means the next pixel closes one. A sync edge moves the machine to FIRST or SINGLE according to the newly loaded port mode. In dual mode each accepted pixel moves the machine from FIRST to SECOND or from SECOND to FIRST. In SINGLE, accepted pixels leave the machine where it is.

Top module: `pix_demux`

## Requirements
- R1: After reset, port A and port B read 0, data clock enable and data valid read 0, and port B output enable reads 1, because the default mode is dual port, simultaneous presentation, first pixel to A.
- R2: A pixel is accepted at a rising clock edge where pix_valid is 1 and hsync is 0. Its effect on the outputs is visible after that same edge.
- R3: In single-port mode (port mode bit 0) every accepted pixel appears on port A with a data clock enable pulse. oe_b is 0, and port B keeps its value.
- R4: In dual interleaved mode (port mode 1, presentation bit 0), accepted pixels update port A and port B on alternate accepts. Each update carries a data clock enable pulse, and the other port holds its value.
- R5: With the phase bit at 0, the first pixel after a sync leading edge and every later odd-numbered pixel go to port A, and the even-numbered pixels go to port B.
- R6: With the phase bit at 1, the assignment of R5 is swapped, so the first pixel goes to port B.
- R7: In dual simultaneous mode (presentation bit 1), the first pixel of a pair changes no output and gives no data clock enable pulse. The second pixel updates both ports in one cycle with one pulse.
- R8: The mode bits are loaded only on a sync leading edge. A change in the middle of a line has no effect until the next sync edge.
- R9: A sync leading edge restarts the pixel count, so the next accepted pixel is again the first of the line.
- R10: data_valid clears in the cycle after a sync leading edge and sets with the first port update of the line.
- R11: When no pixel is accepted, the data clock enable stays 0 and both ports hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync | input | 1 | Horizontal sync, active high. The rising edge starts a line |
| pix_valid | input | 1 | Pixel qualifier |
| pix_in | input | PIX_W | Incoming pixel sample |
| cfg_dual | input | 1 | Port mode: 0 single, 1 dual |
| cfg_simul | input | 1 | Presentation: 0 interleaved, 1 simultaneous |
| cfg_phase_b | input | 1 | 0 first pixel to A, 1 first pixel to B |
| port_a | output | PIX_W | Port A data |
| port_b | output | PIX_W | Port B data |
| oe_b | output | 1 | Port B output enable, 0 means high impedance |
| data_valid | output | 1 | Line data valid |
| dclk_en | output | 1 | One-cycle data clock enable per port update |

## Verification
A wrong parity state shows up at once as a pixel on the wrong port, or, in simultaneous mode, as an update after a lone pixel. Either is visible on the first or second pixel after a sync edge. A mode loaded at the wrong moment shows up as a change of oe_b, or a change of routing, in the middle of a line. A staging register that is not written or not read shows up as a wrong value on one port at the close of the first pair. Each scenario therefore checks the ports after every single pixel, not only at the end of a line.

// File: rtl/pix_demux_pkg.sv
package pix_demux_pkg;
    typedef enum logic [1:0] {
        ST_SINGLE = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } demux_state_t;

    typedef struct packed {
        logic dual;
        logic simul;
        logic phase_b;
    } demux_mode_t;

    localparam demux_mode_t MODE_RESET = '{dual: 1'b1, simul: 1'b1, phase_b: 1'b0};
endpackage

// File: rtl/pix_demux_ctrl.sv
module pix_demux_ctrl
    import pix_demux_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hsync,
    input  logic        pix_valid,
    input  demux_mode_t cfg_mode,
    output logic        sync_edge,
    output logic        accept,
    output logic        second,
    output demux_mode_t act_mode
);
    logic         hsync_q;
    demux_state_t state, state_nxt;

    assign sync_edge = hsync & ~hsync_q;
    assign accept    = pix_valid & ~hsync;
    assign second    = (state == ST_SECOND);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hsync_q  <= 1'b0;
            act_mode <= MODE_RESET;
            state    <= ST_FIRST;
        end else begin
            hsync_q <= hsync;
            state   <= state_nxt;
            if (sync_edge) begin
                act_mode <= cfg_mode;
            end
        end
    end

    always_comb begin
        state_nxt = state;
        if (sync_edge) begin
            state_nxt = cfg_mode.dual ? ST_FIRST : ST_SINGLE;
        end else if (accept) begin
            unique case (state)
                ST_SINGLE: state_nxt = ST_SINGLE;
                ST_FIRST:  state_nxt = ST_SECOND;
                ST_SECOND: state_nxt = ST_FIRST;
                default:   state_nxt = ST_FIRST;
            endcase
        end
    end
endmodule

// File: rtl/pix_demux_route.sv
module pix_demux_route
    import pix_demux_pkg::*;
#(
    parameter int PIX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_edge,
    input  logic             accept,
    input  logic             second,
    input  demux_mode_t      act_mode,
    input  logic [PIX_W-1:0] pix_in,
    output logic [PIX_W-1:0] port_a,
    output logic [PIX_W-1:0] port_b,
    output logic             data_valid,
    output logic             dclk_en
);
    logic [PIX_W-1:0] stage_q;
    logic             to_a;

    // pixel of the current parity goes to A when parity matches the phase bit
    assign to_a = (second == act_mode.phase_b);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_a     <= '0;
            port_b     <= '0;
            stage_q    <= '0;
            data_valid <= 1'b0;
            dclk_en    <= 1'b0;
        end else begin
            dclk_en <= 1'b0;
            if (sync_edge) begin
                data_valid <= 1'b0;
            end
            if (accept) begin
                if (!act_mode.dual) begin
                    port_a     <= pix_in;
                    dclk_en    <= 1'b1;
                    data_valid <= 1'b1;
                end else if (!act_mode.simul) begin
                    if (to_a) port_a <= pix_in;
                    else      port_b <= pix_in;
                    dclk_en    <= 1'b1;
                    data_valid <= 1'b1;
                end else if (!second) begin
                    stage_q <= pix_in;
                end else begin
                    if (act_mode.phase_b) begin
                        port_a <= pix_in;
                        port_b <= stage_q;
                    end else begin
                        port_a <= stage_q;
                        port_b <= pix_in;
                    end
                    dclk_en    <= 1'b1;
                    data_valid <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pix_demux.sv
module pix_demux
    import pix_demux_pkg::*;
#(
    parameter int PIX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix_in,
    input  logic             cfg_dual,
    input  logic             cfg_simul,
    input  logic             cfg_phase_b,
    output logic [PIX_W-1:0] port_a,
    output logic [PIX_W-1:0] port_b,
    output logic             oe_b,
    output logic             data_valid,
    output logic             dclk_en
);
    demux_mode_t cfg_mode, act_mode;
    logic        sync_edge, accept, second;

    assign cfg_mode = '{dual: cfg_dual, simul: cfg_simul, phase_b: cfg_phase_b};
    assign oe_b     = act_mode.dual;

    pix_demux_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .hsync     (hsync),
        .pix_valid (pix_valid),
        .cfg_mode  (cfg_mode),
        .sync_edge (sync_edge),
        .accept    (accept),
        .second    (second),
        .act_mode  (act_mode)
    );

    pix_demux_route #(.PIX_W(PIX_W)) u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_edge  (sync_edge),
        .accept     (accept),
        .second     (second),
        .act_mode   (act_mode),
        .pix_in     (pix_in),
        .port_a     (port_a),
        .port_b     (port_b),
        .data_valid (data_valid),
        .dclk_en    (dclk_en)
    );
endmodule

// File: rtl/pix_demux_checker.sv
module pix_demux_checker #(
    parameter int PIX_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hsync,
    input logic             pix_valid,
    input logic [PIX_W-1:0] port_a,
    input logic [PIX_W-1:0] port_b,
    input logic             oe_b,
    input logic             data_valid,
    input logic             dclk_en,
    input logic             simul_act
);
    logic seen_clk;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_clk <= 1'b0;
        else        seen_clk <= 1'b1;
    end

    // R3: port B is frozen while it is not driven
    a_r3_b_frozen_single: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_b |=> $stable(port_b));

    // R2, R11: an update pulse needs an accepted pixel one edge earlier
    a_r2_dclk_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_clk && dclk_en) |-> $past(pix_valid && !hsync));

    // R11: port A only moves together with an update pulse
    a_r11_port_a_moves_with_dclk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_clk && port_a != $past(port_a)) |-> dclk_en);

    // R10: the line flag drops right after the sync leading edge
    a_r10_sync_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_clk && $rose(hsync)) |=> !data_valid);

    // R7: in simultaneous presentation two pulses never come back to back
    a_r7_simul_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (simul_act && oe_b && dclk_en) |=> !dclk_en);
endmodule

bind pix_demux pix_demux_checker #(.PIX_W(PIX_W)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .hsync      (hsync),
    .pix_valid  (pix_valid),
    .port_a     (port_a),
    .port_b     (port_b),
    .oe_b       (oe_b),
    .data_valid (data_valid),
    .dclk_en    (dclk_en),
    .simul_act  (act_mode.simul)
);

// File: tb/pix_demux_bench.sv
module pix_demux_bench;
    localparam int PIX_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             hsync = 1'b0;
    logic             pix_valid = 1'b0;
    logic [PIX_W-1:0] pix_in = '0;
    logic             cfg_dual = 1'b1;
    logic             cfg_simul = 1'b1;
    logic             cfg_phase_b = 1'b0;
    logic [PIX_W-1:0] port_a, port_b;
    logic             oe_b, data_valid, dclk_en;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pix_demux #(.PIX_W(PIX_W)) u_pix_demux (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .pix_valid(pix_valid),
        .pix_in(pix_in), .cfg_dual(cfg_dual), .cfg_simul(cfg_simul),
        .cfg_phase_b(cfg_phase_b), .port_a(port_a), .port_b(port_b),
        .oe_b(oe_b), .data_valid(data_valid), .dclk_en(dclk_en)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // apply inputs at a falling edge; return at the next falling edge
    task automatic step(input logic hs, input logic v, input int px);
        hsync     = hs;
        pix_valid = v;
        pix_in    = PIX_W'(px);
        @(negedge clk);
    endtask

    task automatic line_start(input logic d, input logic s, input logic p);
        cfg_dual = d; cfg_simul = s; cfg_phase_b = p;
        step(1'b1, 1'b0, 0);
        check("R10 valid cleared", int'(data_valid), 0);
        step(1'b0, 1'b0, 0);
    endtask

    task automatic t_reset();
        check("R1 port_a", int'(port_a), 0);
        check("R1 port_b", int'(port_b), 0);
        check("R1 oe_b", int'(oe_b), 1);
        check("R1 data_valid", int'(data_valid), 0);
        check("R1 dclk_en", int'(dclk_en), 0);
    endtask

    task automatic t_single();
        int b0;
        line_start(1'b0, 1'b1, 1'b1);
        b0 = int'(port_b);
        check("R3 oe_b low", int'(oe_b), 0);
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 1'b1, 11 * (i + 1));
            check("R3 port_a", int'(port_a), 11 * (i + 1));
            check("R3 dclk_en", int'(dclk_en), 1);
            check("R3 port_b held", int'(port_b), b0);
            check("R10 valid set", int'(data_valid), 1);
        end
        step(1'b0, 1'b1, 77);
        check("R2 accept at same edge", int'(port_a), 77);
    endtask

    task automatic t_interleave(input logic ph);
        int first, other;
        line_start(1'b1, 1'b0, ph);
        check("R8 oe_b follows new mode", int'(oe_b), 1);
        for (int i = 1; i <= 4; i++) begin
            step(1'b0, 1'b1, 100 + i);
            first = ((i % 2) == 1) ? 1 : 0;
            if ((first == 1) != ph) begin
                check(ph ? "R6 to A" : "R5 to A", int'(port_a), 100 + i);
                if (i > 1) check("R4 B held", int'(port_b), 100 + i - 1);
            end else begin
                check(ph ? "R6 to B" : "R5 to B", int'(port_b), 100 + i);
                if (i > 1) check("R4 A held", int'(port_a), 100 + i - 1);
            end
            check("R4 dclk_en", int'(dclk_en), 1);
        end
        step(1'b0, 1'b0, 0);
        other = int'(port_a);
        step(1'b0, 1'b0, 0);
        check("R11 idle dclk", int'(dclk_en), 0);
        check("R11 idle port_a", int'(port_a), other);
    endtask

    task automatic t_simul(input logic ph);
        int a0, b0;
        line_start(1'b1, 1'b1, ph);
        a0 = int'(port_a); b0 = int'(port_b);
        step(1'b0, 1'b1, 200);
        check("R7 no pulse on first", int'(dclk_en), 0);
        check("R7 A unchanged", int'(port_a), a0);
        check("R7 B unchanged", int'(port_b), b0);
        check("R10 valid still low", int'(data_valid), 0);
        step(1'b0, 1'b1, 201);
        check("R7 pulse on second", int'(dclk_en), 1);
        check(ph ? "R6 simul A" : "R5 simul A", int'(port_a), ph ? 201 : 200);
        check(ph ? "R6 simul B" : "R5 simul B", int'(port_b), ph ? 200 : 201);
        step(1'b0, 1'b0, 0);
        check("R7 pulse one cycle", int'(dclk_en), 0);
    endtask

    task automatic t_mode_midline();
        line_start(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 300);
        check("R8 first to A", int'(port_a), 300);
        cfg_dual = 1'b0; cfg_phase_b = 1'b1;
        step(1'b0, 1'b1, 301);
        check("R8 still dual, to B", int'(port_b), 301);
        check("R8 oe_b unchanged", int'(oe_b), 1);
        check("R8 port_a held", int'(port_a), 300);
    endtask

    task automatic t_parity_restart();
        line_start(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 400);
        check("R9 first to A", int'(port_a), 400);
        line_start(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 401);
        check("R9 restart to A", int'(port_a), 401);
        check("R9 B untouched", int'(port_b) == 401 ? 1 : 0, 0);
    endtask

    task automatic t_sync_blocks_pixel();
        int a0;
        line_start(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b1, 500);
        a0 = int'(port_a);
        step(1'b1, 1'b1, 501);
        check("R2 no accept in sync", int'(port_a), a0);
        check("R2 no pulse in sync", int'(dclk_en), 0);
        step(1'b0, 1'b0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_interleave(1'b0);
        t_interleave(1'b1);
        t_simul(1'b0);
        t_simul(1'b1);
        t_mode_midline();
        t_parity_restart();
        t_sync_blocks_pixel();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule